// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog timer controlled through a byte-wide synchronous register port. Once armed, an internal counter advances on every clock. Software must restart it by writing a fixed key value to a write-only kick register before the programmed time-out elapses. If the time-out is reached, or the kick is illegal, the block raises a reset request. The request is a single-cycle pulse meant for the chip's reset controller, and the counter starts over.

An optional window mode rejects kicks that arrive too early. While the counter is still inside a programmable closed window, a correct key counts as a fault, the same as a missed deadline. A separate early-warning point, also programmable, sets a sticky flag. The flag can be routed to an interrupt line through an enable. All three durations use a 4-bit code that selects a power-of-two cycle count. A lock bit freezes the arming and timing setup until the next reset.

Reads return data one cycle after the address is presented. A status bit shows a short busy indication after writes that change the watchdog's operation.

Top module: `wdog_win_top`

## Requirements
- R1: After reset, the registers read control 0x00 (offset 0x0), timing 0xBB (offset 0x1), warning 0x0B (offset 0x2), enable-clear and enable-set 0x00 (offsets 0x4/0x5), flag 0x00 (offset 0x6) and status 0x00 (offset 0x7). `rst_req` and `irq` are low.
- R2: The control register keeps only bit 1 (arm), bit 2 (window mode) and bit 7 (lock), and all other control bits read as zero. The warning register keeps only bits 3:0. The kick register (offset 0x8) and unmapped offsets read as zero.
- R3: Timing bits 3:0 hold the period code n, giving a period of 8<<n cycles. Armed at clock edge E, with no kick, the block pulses `rst_req` high for exactly one cycle after edge E+period. The counter then restarts, so the next pulse follows after edge E+2*period.
- R4: Any code above 0xB, for the period, the window or the warning, selects the 16384-cycle setting.
- R5: Writing 0xA5 to offset 0x8 while armed restarts the counter without a reset request. The next time-out pulse then follows one full period after that write's edge. In normal mode this holds however early the kick arrives.
- R6: Writing any value other than 0xA5 to offset 0x8 while armed pulses `rst_req` right after that write's edge and restarts the counter.
- R7: Timing bits 7:4 hold the window code w. In window mode, a 0xA5 kick made while the counter is below 8<<w (the counter is zero right after arming or restart) raises `rst_req` as a fault. A kick made with the counter at or above 8<<w is accepted.
- R8: While not armed, the counter does not run, no `rst_req` is produced, and kick writes, including bad keys, have no effect.
- R9: When the armed counter reaches (8<<e)-1 cycles since the last restart, with e in warning bits 3:0, the warning flag (flag register bit 0) sets. The registered `irq` output equals flag AND enable and rises with the flag.
- R10: Writing 1 in bit 0 of offset 0x5 sets the warning interrupt enable, and writing 1 in bit 0 of offset 0x4 clears it. Both offsets read the enable in bit 0.
- R11: Writing 1 to flag bit 0 clears the warning flag, and writing 0 leaves it set.
- R12: Status bit 7 reads 1 for two cycles after a write to control, timing or kick, and is 0 otherwise (for example after a warning-register write).
- R13: With the lock bit set, writes to control and timing are ignored and the lock stays set until reset, so the armed timing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the offset of the previous cycle |
| irq | output | 1 | Early-warning interrupt, registered |
| rst_req | output | 1 | Single-cycle reset request |

## Verification
The bench builds the block with its default parameters: an 8-cycle base unit, codes saturating at 0xB, a two-cycle busy time and key 0xA5. The bench drives codes 0 to 3, so periods, windows and warning points last 8 to 64 cycles. That lets it check the exact edge of every time-out, the first and last closed-window cycles, and the warning rise within a few hundred clocks. One saturated code (0xC) is run through the full 16384-cycle period to pin the upper boundary.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  // Register offsets seen by software
  localparam logic [ADDR_W-1:0] OFF_CTL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_TIME  = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_WARN  = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_IECLR = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_IESET = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_FLAG  = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 4'h7;
  localparam logic [ADDR_W-1:0] OFF_KICK  = 4'h8;

  // Field positions
  localparam int BIT_ARM  = 1;
  localparam int BIT_WIN  = 2;
  localparam int BIT_LOCK = 7;
  localparam int BIT_BUSY = 7;

  localparam logic [DATA_W-1:0] TIME_RST = 8'hBB;
  localparam logic [3:0]        WARN_RST = 4'hB;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY      = 8'hA5,
  parameter int                BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              ew_hit,
  output logic              run_en,
  output logic              win_en,
  output logic [3:0]        per_code,
  output logic [3:0]        win_code,
  output logic [3:0]        ew_code,
  output logic              kick_stb,
  output logic              kick_ok
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic              arm_q, win_q, lock_q;
  logic [DATA_W-1:0] time_q;
  logic [3:0]        warn_q;
  logic              ie_q, flag_q, irq_q;
  logic              ie_n, flag_n;
  logic [BW-1:0]     busy_q;
  logic [DATA_W-1:0] rd_n, rd_q;
  logic              wr_ctl, wr_time, wr_warn, wr_ieclr, wr_ieset, wr_flag;

  assign wr_ctl   = bus_we && bus_addr == OFF_CTL;
  assign wr_time  = bus_we && bus_addr == OFF_TIME;
  assign wr_warn  = bus_we && bus_addr == OFF_WARN;
  assign wr_ieclr = bus_we && bus_addr == OFF_IECLR;
  assign wr_ieset = bus_we && bus_addr == OFF_IESET;
  assign wr_flag  = bus_we && bus_addr == OFF_FLAG;
  assign kick_stb = bus_we && bus_addr == OFF_KICK;
  assign kick_ok  = bus_wdata == KEY;

  always_comb begin
    ie_n = ie_q;
    if (wr_ieset && bus_wdata[0]) ie_n = 1'b1;
    else if (wr_ieclr && bus_wdata[0]) ie_n = 1'b0;
    flag_n = flag_q;
    if (ew_hit) flag_n = 1'b1;
    else if (wr_flag && bus_wdata[0]) flag_n = 1'b0;
  end

  always_comb begin
    rd_n = '0;
    unique case (bus_addr)
      OFF_CTL: begin
        rd_n[BIT_ARM]  = arm_q;
        rd_n[BIT_WIN]  = win_q;
        rd_n[BIT_LOCK] = lock_q;
      end
      OFF_TIME:             rd_n = time_q;
      OFF_WARN:             rd_n[3:0] = warn_q;
      OFF_IECLR, OFF_IESET: rd_n[0] = ie_q;
      OFF_FLAG:             rd_n[0] = flag_q;
      OFF_STAT:             rd_n[BIT_BUSY] = busy_q != '0;
      default:              rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      win_q  <= 1'b0;
      lock_q <= 1'b0;
      time_q <= TIME_RST;
      warn_q <= WARN_RST;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      busy_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_ctl && !lock_q) begin
        arm_q  <= bus_wdata[BIT_ARM];
        win_q  <= bus_wdata[BIT_WIN];
        lock_q <= bus_wdata[BIT_LOCK];
      end
      if (wr_time && !lock_q) time_q <= bus_wdata;
      if (wr_warn) warn_q <= bus_wdata[3:0];
      ie_q   <= ie_n;
      flag_q <= flag_n;
      irq_q  <= flag_n & ie_n;
      if (wr_ctl || wr_time || kick_stb) busy_q <= BW'(BUSY_CYC);
      else if (busy_q != '0) busy_q <= busy_q - 1'b1;
      rd_q <= rd_n;
    end
  end

  assign bus_rdata = rd_q;
  assign irq       = irq_q;
  assign run_en    = arm_q;
  assign win_en    = win_q;
  assign per_code  = time_q[3:0];
  assign win_code  = time_q[7:4];
  assign ew_code   = warn_q;

  // R9: the flag only rises after a warning hit from the counter
  a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(ew_hit));

  // R11: the flag only falls after a write of 1 to its bit
  a_r11_flag_w1c: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(bus_we && bus_addr == OFF_FLAG && bus_wdata[0]));

  // R13: the lock holds itself and the timing setup
  a_r13_lock_hold: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> (lock_q && $stable(time_q) && $stable(arm_q)));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int BASE_SHIFT = 3,
  parameter int MAX_CODE   = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_en,
  input  logic       win_en,
  input  logic [3:0] per_code,
  input  logic [3:0] win_code,
  input  logic [3:0] ew_code,
  input  logic       kick_stb,
  input  logic       kick_ok,
  output logic       ew_hit,
  output logic       rst_req
);
  localparam int CW    = BASE_SHIFT + MAX_CODE + 1;
  localparam int NLIM  = 3;
  localparam int I_PER = 0;
  localparam int I_WIN = 1;
  localparam int I_EW  = 2;

  function automatic logic [CW-1:0] span(input logic [3:0] code);
    logic [3:0] sat;
    sat = (code > 4'(MAX_CODE)) ? 4'(MAX_CODE) : code;
    return CW'(1) << (BASE_SHIFT + int'(sat));
  endfunction

  logic [3:0]    codes [NLIM];
  logic [CW-1:0] lims  [NLIM];
  logic [CW-1:0] cnt_q;
  logic          rst_req_q;
  logic          win_closed;

  assign codes[I_PER] = per_code;
  assign codes[I_WIN] = win_code;
  assign codes[I_EW]  = ew_code;

  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    assign lims[i] = span(codes[i]);
  end

  assign win_closed = win_en && (cnt_q < lims[I_WIN]);
  assign ew_hit     = run_en && (cnt_q == lims[I_EW] - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (!run_en) begin
        cnt_q <= '0;
      end else if (kick_stb) begin
        cnt_q <= '0;
        if (!kick_ok || win_closed) rst_req_q <= 1'b1;
      end else if (cnt_q == lims[I_PER] - 1'b1) begin
        cnt_q     <= '0;
        rst_req_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_req = rst_req_q;

  // R3: every request coincides with a restarted counter
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> cnt_q == '0);

  // R6: a wrong key while armed leads to a request
  a_r6_bad_key: assert property (@(posedge clk) disable iff (rst)
    (run_en && kick_stb && !kick_ok) |=> rst_req_q);

  // R7: a key inside the closed window is a fault
  a_r7_early_kick: assert property (@(posedge clk) disable iff (rst)
    (run_en && kick_stb && kick_ok && win_en && cnt_q < lims[I_WIN]) |=> rst_req_q);

  // R8: nothing is requested while disarmed
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !rst_req_q);
endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
  import wdog_pkg::*;
#(
  parameter int                BASE_SHIFT = 3,
  parameter int                MAX_CODE   = 11,
  parameter int                BUSY_CYC   = 2,
  parameter logic [DATA_W-1:0] KEY        = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic       run_en, win_en, kick_stb, kick_ok, ew_hit;
  logic [3:0] per_code, win_code, ew_code;

  wdog_regs #(.KEY(KEY), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .ew_hit(ew_hit),
    .run_en(run_en), .win_en(win_en),
    .per_code(per_code), .win_code(win_code), .ew_code(ew_code),
    .kick_stb(kick_stb), .kick_ok(kick_ok)
  );

  wdog_core #(.BASE_SHIFT(BASE_SHIFT), .MAX_CODE(MAX_CODE)) u_core (
    .clk(clk), .rst(rst),
    .run_en(run_en), .win_en(win_en),
    .per_code(per_code), .win_code(win_code), .ew_code(ew_code),
    .kick_stb(kick_stb), .kick_ok(kick_ok),
    .ew_hit(ew_hit), .rst_req(rst_req)
  );
endmodule

// File: tb/wdog_win_top_tb.sv
`timescale 1ns/1ps
module wdog_win_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, rst_req;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  wdog_win_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // steps n cycles, returning how many of them showed rst_req high
  task automatic watch(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rst_req", int'(rst_req), 0);
    check("R1 irq", int'(irq), 0);
    rd(4'h0, d); check("R1 control", d, 8'h00);
    rd(4'h1, d); check("R1 timing", d, 8'hBB);
    rd(4'h2, d); check("R1 warning", d, 8'h0B);
    rd(4'h4, d); check("R1 enable-clear", d, 8'h00);
    rd(4'h5, d); check("R1 enable-set", d, 8'h00);
    rd(4'h6, d); check("R1 flag", d, 8'h00);
    rd(4'h7, d); check("R1 status", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(4'h0, 8'h79); rd(4'h0, d); check("R2 control reserved", d, 8'h00);
    wr(4'h0, 8'h04); rd(4'h0, d); check("R2 window bit kept", d, 8'h04);
    wr(4'h0, 8'h00);
    wr(4'h2, 8'hF3); rd(4'h2, d); check("R2 warning mask", d, 8'h03);
    wr(4'h2, 8'h0B);
    rd(4'h8, d); check("R2 kick reads zero", d, 8'h00);
    rd(4'h3, d); check("R2 hole reads zero", d, 8'h00);
  endtask

  task automatic t_disabled();
    int h;
    logic [7:0] d;
    wr(4'h1, 8'h00);
    wr(4'h8, 8'h00);
    watch(40, h); check("R8 no request while disarmed", h, 0);
    rd(4'h6, d); check("R8 no flag while disarmed", d, 8'h00);
  endtask

  task automatic t_period();
    int h;
    wr(4'h1, 8'h01);
    wr(4'h0, 8'h02);
    watch(15, h); check("R3 quiet before period", h, 0);
    step(1); check("R3 pulse at period", int'(rst_req), 1);
    step(1); check("R3 pulse one cycle", int'(rst_req), 0);
    watch(14, h); check("R3 quiet second period", h, 0);
    step(1); check("R3 pulse repeats", int'(rst_req), 1);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_sat();
    int h;
    wr(4'h1, 8'h0C);
    wr(4'h0, 8'h02);
    watch(16383, h); check("R4 saturated code quiet", h, 0);
    step(1); check("R4 saturated code pulse at 16384", int'(rst_req), 1);
    wr(4'h0, 8'h00);
    wr(4'h6, 8'h01);
  endtask

  task automatic t_kick();
    int h;
    wr(4'h1, 8'h02);
    wr(4'h0, 8'h02);
    step(10);
    wr(4'h8, 8'hA5);
    check("R5 accepted kick no request", int'(rst_req), 0);
    watch(31, h); check("R5 restart delays time-out", h, 0);
    step(1); check("R5 time-out one period after kick", int'(rst_req), 1);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_badkey();
    int h;
    wr(4'h1, 8'h02);
    wr(4'h0, 8'h02);
    step(5);
    wr(4'h8, 8'h5A);
    check("R6 bad key request", int'(rst_req), 1);
    watch(31, h); check("R6 counter restarted", h, 0);
    step(1); check("R6 next time-out", int'(rst_req), 1);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_window();
    wr(4'h1, 8'h12);
    wr(4'h0, 8'h06);
    step(4);
    wr(4'h8, 8'hA5);
    check("R7 early kick fault", int'(rst_req), 1);
    step(16);
    wr(4'h8, 8'hA5);
    check("R7 kick at window end accepted", int'(rst_req), 0);
    step(15);
    wr(4'h8, 8'hA5);
    check("R7 kick on last closed cycle fault", int'(rst_req), 1);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_warn();
    logic [7:0] d;
    wr(4'h1, 8'h03);
    wr(4'h2, 8'h01);
    wr(4'h5, 8'h01);
    rd(4'h4, d); check("R10 enable via clear offset", d, 8'h01);
    rd(4'h5, d); check("R10 enable via set offset", d, 8'h01);
    wr(4'h0, 8'h02);
    step(15); check("R9 irq low before warning", int'(irq), 0);
    step(1);  check("R9 irq at warning point", int'(irq), 1);
    rd(4'h6, d); check("R9 flag set", d, 8'h01);
    wr(4'h6, 8'h00); rd(4'h6, d); check("R11 write 0 keeps flag", d, 8'h01);
    wr(4'h4, 8'h01);
    check("R10 irq drops with enable", int'(irq), 0);
    rd(4'h5, d); check("R10 enable cleared", d, 8'h00);
    wr(4'h6, 8'h01); rd(4'h6, d); check("R11 write 1 clears flag", d, 8'h00);
    wr(4'h0, 8'h00);
    wr(4'h2, 8'h0B);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    wr(4'h1, 8'h03);
    rd(4'h7, d); check("R12 busy after timing write", d, 8'h80);
    step(1);
    rd(4'h7, d); check("R12 busy ends", d, 8'h00);
    wr(4'h2, 8'h0B);
    rd(4'h7, d); check("R12 warning write not busy", d, 8'h00);
  endtask

  task automatic t_lock();
    int h;
    logic [7:0] d;
    wr(4'h1, 8'h02);
    wr(4'h0, 8'h82);
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h05);
    rd(4'h0, d); check("R13 control locked", d, 8'h82);
    rd(4'h1, d); check("R13 timing locked", d, 8'h02);
    watch(27, h); check("R13 quiet under lock", h, 0);
    step(1); check("R13 locked period still 32", int'(rst_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_disabled();
    t_period();
    t_sat();
    t_kick();
    t_badkey();
    t_window();
    t_warn();
    t_busy();
    t_lock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule